// File: doc/BRIEF.md
# Dual-Clock Word Buffer with Programmable Threshold Flags

This block is a first-in first-out store of 9-bit words between two unrelated, free-running clocks. The producer side writes on its own clock through a pair of write enables. The consumer side reads on its own clock through a pair of read enables, and each read loads a registered output. Four active-low status outputs report the fill level. Empty and almost-empty belong to the read clock. Full and almost-full belong to the write clock. Each flag compares an occupancy that is computed in its own domain.

The read and write positions are binary counters one bit wider than the address. Each is passed to the opposite domain in Gray code through a two-stage synchronizer. The depth is a power of two set by `ADDR_W`. A production build would use 14 address bits (16K words), and smaller values are used for simulation.

The second write-enable pin has two roles. Its level while reset is active chooses one of them. When held high, the pin is a plain second write enable and both thresholds are fixed at `DEF_OFS` (default 7). When held low, the thresholds come from the `ae_ofs` and `af_ofs` inputs. In that role, a low level on the pin hands the access to an external offset store, so the FIFO neither stores nor delivers a word while the pin is low.

Top module: `twoclk_pflag_fifo`

## Requirements
- R1: A word is stored at a rising `wr_clk` edge only when `wen1_n` is 0, `wen2_ld` is 1 and `ff_n` is 1. In pair-enable mode, `wen2_ld` = 0 blocks the write.
- R2: A word is taken at a rising `rd_clk` edge only when `ren1_n` and `ren2_n` are both 0 and `ef_n` is 1. Words leave in the order they were stored.
- R3: `ff_n` is registered on `wr_clk` and is 0 exactly when 2^ADDR_W words are unread. While it is 0, write attempts store nothing.
- R4: `ef_n` is registered on `rd_clk` and is 0 exactly when no word is unread. While it is 0, read attempts leave `dout` holding the last word read.
- R5: `pae_n` is registered on `rd_clk`. It is 0 when the unread count is n or less, and 1 when the count is n+1 or more, where n is the empty offset.
- R6: `paf_n` is registered on `wr_clk`. It is 0 when the unread count is at least 2^ADDR_W − m, where m is the full offset, and 1 otherwise.
- R7: `wen2_ld` is sampled while reset is active and during the two write-clock cycles of reset release. A value of 1 selects pair-enable mode, where n = m = `DEF_OFS`. A value of 0 selects load-select mode, where n = `ae_ofs` and m = `af_ofs`, and `wen2_ld` = 0 blocks both FIFO writes and FIFO reads.
- R8: After reset, `ef_n` = 0, `pae_n` = 0, `ff_n` = 1, `paf_n` = 1 and `dout` = 0.
- R9: After a write into an empty FIFO, `dout` still shows its old value until `ef_n` rises. The written word appears on the first read edge after that.
- R10: `dout_drive_en` is the inverse of `oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| din | input | DATA_W | Word to store |
| wen1_n | input | 1 | Primary write enable, active low |
| wen2_ld | input | 1 | Second write enable, or load select, chosen at reset |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ae_ofs | input | ADDR_W | Almost-empty offset in load-select mode |
| af_ofs | input | ADDR_W | Almost-full offset in load-select mode |
| dout | output | DATA_W | Registered read word |
| dout_drive_en | output | 1 | High when the output bus should be driven |
| ef_n | output | 1 | Empty, active low |
| ff_n | output | 1 | Full, active low |
| pae_n | output | 1 | Almost empty, active low |
| paf_n | output | 1 | Almost full, active low |

## Verification
The bench builds the block with `ADDR_W` = 4, so a 16-word store fills and drains within a few dozen cycles. At that depth every threshold crossing is reachable: the default offset of 7 puts almost-full at 9 words, and load-select offsets of 3 and 5 move the thresholds to 3 and 11 words. The write clock runs at 8 ns and the read clock at 11 ns. This ratio moves the pointer crossings across both domains during the random phase.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;
  typedef enum logic {
    EN_PAIR  = 1'b0,
    OFS_LOAD = 1'b1
  } wen2_mode_e;
endpackage

// File: rtl/fifo_pf_rstsync.sv
module fifo_pf_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage <= 2'b00;
    else         stage <= {stage[0], 1'b1};
  end

  assign srst_n = stage[1];
endmodule

// File: rtl/fifo_pf_sync.sv
module fifo_pf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fifo_pf_ram.sv
module fifo_pf_ram #(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  q <= '0;
    else if (re)  q <= mem[raddr];
  end
endmodule

// File: rtl/fifo_pf_wr.sv
module fifo_pf_wr
  import fifo_pf_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DEF_OFS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen1_n,
  input  logic          wen2,
  input  logic [AW-1:0] af_ofs,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic          ff_n,
  output logic          paf_n,
  output logic          ld_mode
);
  localparam logic [AW-1:0] DEF_M    = AW'(DEF_OFS);
  localparam logic [AW:0]   FULL_LVL = {1'b1, {AW{1'b0}}};

  wen2_mode_e  mode;
  logic [AW:0] wbin, wbin_nx, wgray_nx, rbin_s, used_nx, af_lvl;
  logic [AW-1:0] m_ofs;
  logic        ff_nx, paf_nx;

  always_comb begin
    rbin_s[AW] = rgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
    we       = !wen1_n && wen2 && ff_n;
    wbin_nx  = wbin + {{AW{1'b0}}, we};
    wgray_nx = wbin_nx ^ (wbin_nx >> 1);
    used_nx  = wbin_nx - rbin_s;
    m_ofs    = (mode == OFS_LOAD) ? af_ofs : DEF_M;
    af_lvl   = FULL_LVL - {1'b0, m_ofs};
    ff_nx    = (used_nx != FULL_LVL);
    paf_nx   = (used_nx < af_lvl);
  end

  // mode capture: loads on every edge while the domain is held in reset
  always_ff @(posedge clk) begin
    if (!rst_n) mode <= wen2 ? EN_PAIR : OFS_LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      ff_n  <= 1'b1;
      paf_n <= 1'b1;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
      ff_n  <= ff_nx;
      paf_n <= paf_nx;
    end
  end

  assign waddr   = wbin[AW-1:0];
  assign ld_mode = (mode == OFS_LOAD);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wbin - rbin_s) <= FULL_LVL);
  a_r6_full_implies_almost: assert property (@(posedge clk) disable iff (!rst_n)
    !ff_n |-> !paf_n);
  a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/fifo_pf_rd.sv
module fifo_pf_rd #(
  parameter int AW      = 4,
  parameter int DEF_OFS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic          ld_pin,
  input  logic          ld_mode,
  input  logic [AW-1:0] ae_ofs,
  input  logic [AW:0]   wgray_s,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic          re,
  output logic          ef_n,
  output logic          pae_n
);
  localparam logic [AW-1:0] DEF_N    = AW'(DEF_OFS);
  localparam logic [AW:0]   FULL_LVL = {1'b1, {AW{1'b0}}};

  logic [AW:0]   rbin, rbin_nx, rgray_nx, wbin_s, avail_nx;
  logic [AW-1:0] n_ofs;
  logic          ef_nx, pae_nx;

  always_comb begin
    wbin_s[AW] = wgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
    re       = !ren1_n && !ren2_n && ef_n && (!ld_mode || ld_pin);
    rbin_nx  = rbin + {{AW{1'b0}}, re};
    rgray_nx = rbin_nx ^ (rbin_nx >> 1);
    avail_nx = wbin_s - rbin_nx;
    n_ofs    = ld_mode ? ae_ofs : DEF_N;
    ef_nx    = (avail_nx != '0);
    pae_nx   = (avail_nx > {1'b0, n_ofs});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      ef_n  <= 1'b0;
      pae_n <= 1'b0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rgray_nx;
      ef_n  <= ef_nx;
      pae_n <= pae_nx;
    end
  end

  assign raddr = rbin[AW-1:0];

  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wbin_s - rbin) <= FULL_LVL);
  a_r5_empty_implies_almost: assert property (@(posedge clk) disable iff (!rst_n)
    !ef_n |-> !pae_n);
endmodule

// File: rtl/twoclk_pflag_fifo.sv
module twoclk_pflag_fifo #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 9,
  parameter int DEF_OFS = 7
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              wen1_n,
  input  logic              wen2_ld,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] ae_ofs,
  input  logic [ADDR_W-1:0] af_ofs,
  output logic [DATA_W-1:0] dout,
  output logic              dout_drive_en,
  output logic              ef_n,
  output logic              ff_n,
  output logic              pae_n,
  output logic              paf_n
);
  localparam int PW = ADDR_W + 1;

  logic          wrst_n, rrst_n, we, re, ld_mode_w;
  logic [0:0]    ld_mode_r;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [ADDR_W-1:0] waddr, raddr;

  fifo_pf_rstsync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wrst_n));
  fifo_pf_rstsync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rrst_n));

  fifo_pf_wr #(.AW(ADDR_W), .DEF_OFS(DEF_OFS)) u_wr (
    .clk(wr_clk), .rst_n(wrst_n), .wen1_n(wen1_n), .wen2(wen2_ld),
    .af_ofs(af_ofs), .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr),
    .we(we), .ff_n(ff_n), .paf_n(paf_n), .ld_mode(ld_mode_w)
  );

  fifo_pf_rd #(.AW(ADDR_W), .DEF_OFS(DEF_OFS)) u_rd (
    .clk(rd_clk), .rst_n(rrst_n), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .ld_pin(wen2_ld), .ld_mode(ld_mode_r[0]), .ae_ofs(ae_ofs),
    .wgray_s(wgray_s), .rgray(rgray), .raddr(raddr), .re(re),
    .ef_n(ef_n), .pae_n(pae_n)
  );

  fifo_pf_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
  fifo_pf_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  fifo_pf_sync #(.W(1))  u_mode (.clk(rd_clk), .rst_n(rrst_n), .d(ld_mode_w), .q(ld_mode_r));

  fifo_pf_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(din),
    .rclk(rd_clk), .rrst_n(rrst_n), .re(re), .raddr(raddr), .q(dout)
  );

  assign dout_drive_en = !oe_n;

  a_r4_hold_when_empty: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    !ef_n |=> $stable(dout));
endmodule

// File: tb/twoclk_pflag_fifo_test.sv
`timescale 1ns/1ps
module twoclk_pflag_fifo_test;
  localparam int AW = 4;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic wen1_n = 1'b1, wen2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b0;
  logic [AW-1:0] ae_ofs = 4'd3, af_ofs = 4'd5;
  logic [DW-1:0] dout;
  logic dout_drive_en, ef_n, ff_n, pae_n, paf_n;

  int vectors = 0, fails = 0;
  bit tb_ld = 1'b0;
  logic [DW-1:0] sb[$];
  logic [DW-1:0] last_rd = '0;

  always #4    wr_clk = ~wr_clk;
  always #5.5  rd_clk = ~rd_clk;

  twoclk_pflag_fifo #(.ADDR_W(AW), .DATA_W(DW), .DEF_OFS(7)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .din(din),
    .wen1_n(wen1_n), .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .oe_n(oe_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .dout(dout),
    .dout_drive_en(dout_drive_en), .ef_n(ef_n), .ff_n(ff_n),
    .pae_n(pae_n), .paf_n(paf_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // driver side of the scoreboard: every accepted write pushes its word (R1, R3)
  initial forever begin
    @(posedge wr_clk);
    if (rst_n && !wen1_n && wen2_ld && ff_n) sb.push_back(din);
  end

  // monitor: every accepted read pops and compares (R2, R7)
  initial forever begin
    @(posedge rd_clk);
    if (rst_n && !ren1_n && !ren2_n && ef_n && (!tb_ld || wen2_ld)) begin
      #1;
      vectors++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R2: actual read %0h expected no read", dout);
      end else begin
        logic [DW-1:0] e;
        e = sb.pop_front();
        if (dout !== e) begin
          fails++;
          $display("FAIL R2: actual %0h expected %0h", dout, e);
        end
        last_rd = e;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge wr_clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  task automatic do_reset(input bit load);
    rst_n = 1'b0; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    wen2_ld = !load;
    repeat (5) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (6) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);
    sb.delete();
    tb_ld = load;
    wen2_ld = 1'b1;
    @(negedge rd_clk);
    chk("R8 ef_n", ef_n, 0); chk("R8 pae_n", pae_n, 0);
    chk("R8 ff_n", ff_n, 1); chk("R8 paf_n", paf_n, 1);
    chk("R8 dout", dout, 0);
  endtask

  task automatic wr_one(input logic [DW-1:0] d);
    @(negedge wr_clk); din = d; wen1_n = 1'b0;
    @(negedge wr_clk); wen1_n = 1'b1;
  endtask

  task automatic rd_one();
    @(negedge rd_clk); ren1_n = 1'b0; ren2_n = 1'b0;
    @(negedge rd_clk); ren1_n = 1'b1; ren2_n = 1'b1;
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
    @(negedge rd_clk);
  endtask

  initial begin
    // ---------- pair-enable mode, offsets fixed at 7 ----------
    do_reset(1'b0);
    // R1: second enable low blocks the write
    @(negedge wr_clk); din = 9'h1AA; wen2_ld = 1'b0; wen1_n = 1'b0;
    @(negedge wr_clk); wen1_n = 1'b1; wen2_ld = 1'b1;
    settle();
    chk("R1 wen2 low stores nothing", ef_n, 0);
    // R3/R6 fill with exact write-side count
    for (int k = 1; k <= DEPTH; k++) begin
      wr_one(9'(k + 9'h40));
      chk("R6 paf_n default offset", paf_n, (k >= DEPTH - 7) ? 0 : 1);
      chk("R3 ff_n", ff_n, (k == DEPTH) ? 0 : 1);
    end
    for (int k = 0; k < 3; k++) wr_one(9'h1FF);
    chk("R3 full stays full", ff_n, 0);
    settle();
    chk("R4 ef_n after fill", ef_n, 1);
    chk("R5 pae_n after fill", pae_n, 1);
    // drain with exact read-side count
    for (int k = DEPTH - 1; k >= 0; k--) begin
      rd_one();
      chk("R5 pae_n default offset", pae_n, (k > 7) ? 1 : 0);
      chk("R4 ef_n", ef_n, (k != 0) ? 1 : 0);
    end
    chk("R3 blocked words not stored", sb.size(), 0);
    for (int k = 0; k < 2; k++) rd_one();
    chk("R4 dout held when empty", dout, 9'(DEPTH + 9'h40));
    // R9 first-word latency
    wr_one(9'h155);
    begin
      int t = 0;
      while (!ef_n && t < 50) begin @(negedge rd_clk); t++; end
    end
    chk("R9 ef_n rose", ef_n, 1);
    chk("R9 dout not yet updated", dout, 9'(DEPTH + 9'h40));
    ren1_n = 1'b0; ren2_n = 1'b0;
    @(negedge rd_clk); ren1_n = 1'b1; ren2_n = 1'b1;
    chk("R9 first word on first read", dout, 9'h155);
    // R10
    oe_n = 1'b1; #1 chk("R10 drive off", dout_drive_en, 0);
    oe_n = 1'b0; #1 chk("R10 drive on", dout_drive_en, 1);

    // ---------- random traffic, unrelated clocks ----------
    fork
      begin
        repeat (300) begin
          @(negedge wr_clk);
          din = 9'($urandom);
          wen1_n = ($urandom_range(0, 9) < 6) ? 1'b0 : 1'b1;
          wen2_ld = ($urandom_range(0, 9) < 8) ? 1'b1 : 1'b0;
        end
        @(negedge wr_clk); wen1_n = 1'b1; wen2_ld = 1'b1;
      end
      begin
        repeat (400) begin
          @(negedge rd_clk);
          ren1_n = ($urandom_range(0, 9) < 5) ? 1'b0 : 1'b1;
          ren2_n = ($urandom_range(0, 9) < 8) ? 1'b0 : 1'b1;
        end
      end
    join
    repeat (6) @(negedge wr_clk);
    @(negedge rd_clk); ren1_n = 1'b0; ren2_n = 1'b0;
    repeat (40) @(negedge rd_clk);
    ren1_n = 1'b1; ren2_n = 1'b1;
    chk("R2 random order drained", sb.size(), 0);
    chk("R4 empty after random drain", ef_n, 0);

    // ---------- load-select mode, offsets 3 and 5 ----------
    ae_ofs = 4'd3; af_ofs = 4'd5;
    do_reset(1'b1);
    for (int k = 1; k <= 11; k++) begin
      wr_one(9'(k + 9'h100));
      chk("R7 paf_n port offset", paf_n, (k >= DEPTH - 5) ? 0 : 1);
    end
    // R7: load select low blocks writes
    @(negedge wr_clk); wen2_ld = 1'b0; wen1_n = 1'b0;
    repeat (3) @(negedge wr_clk);
    wen1_n = 1'b1; wen2_ld = 1'b1;
    settle();
    chk("R7 ld low stored nothing", ff_n, 1);
    chk("R7 pae_n above 3", pae_n, 1);
    // R7: load select low blocks reads
    @(negedge wr_clk); wen2_ld = 1'b0;
    @(negedge rd_clk); ren1_n = 1'b0; ren2_n = 1'b0;
    repeat (3) @(negedge rd_clk);
    ren1_n = 1'b1; ren2_n = 1'b1;
    chk("R7 ld low read blocked", dout, 0);
    @(negedge wr_clk); wen2_ld = 1'b1;
    for (int k = 10; k >= 0; k--) begin
      rd_one();
      chk("R5 pae_n port offset", pae_n, (k > 3) ? 1 : 0);
      chk("R4 ef_n load mode", ef_n, (k != 0) ? 1 : 0);
    end
    chk("R7 only 11 words delivered", sb.size(), 0);
    chk("R2 last word", dout, 9'h10B);
    summary();
  end
endmodule